// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block collects interrupt causes for a serial-peripheral master and folds them into one interrupt line. Single-cycle event pulses from the FIFO and transfer logic set bits in a sticky status register. Two receive-side level conditions, data present and receive storage full, are also set into the status register, but only on a cycle in which software touches any register. A status bit never clears by itself. Software changes status bits by writing a mask, and the written ones flip the matching bits.

A per-cause enable register and a master enable bit in bit 31 of a global enable register decide whether a pending cause reaches the interrupt output. The output is registered. It moves on the same clock edge as the register update that changes it. All three registers sit on a simple 32-bit register port with byte addresses. The status register is at 0x20, the cause enables are at 0x28 and the global enable is at 0x1C.

Top module: `irq_status_agg`

## Requirements
- R1: After synchronous reset the status, enable and global enable registers are zero, `irq` is low and `bus_rdata` is zero.
- R2: A pulse on `ev_tx_empty`, `ev_tx_underrun`, `ev_rx_full`, `ev_rx_overrun` or `ev_tx_half` sets status bit 2, 3, 4, 5 or 6 respectively at the next edge. A pulse on `ev_xfer_done` sets both bit 2 and bit 8.
- R3: A write to 0x20 replaces the status with the stored value XOR the written value, restricted to the implemented bits. Writing a one flips that bit, and writing a zero leaves it unchanged.
- R4: On any cycle with `bus_rd` or `bus_wr` high, whatever the address, `lvl_rx_nonempty` high sets status bit 8 and `lvl_rx_full` high sets status bit 4. Without an access the levels have no effect. These bits are never cleared automatically.
- R5: Only status bits 2, 3, 4, 5, 6 and 8 exist (mask 0x17C). Other positions read as zero and ignore writes.
- R6: A write to 0x28 stores the written value masked to 0x17C. A write to 0x1C stores only bit 31. Every other bit of these registers reads as zero.
- R7: `irq` is registered and equals bit 31 of the global enable AND the OR over (status AND enable), all taken after the same edge's update.
- R8: A read returns, one cycle later on `bus_rdata`, the register contents as they were before that cycle's update. Other addresses return zero. `bus_rdata` holds between reads.
- R9: If an event or level set and a status write hit the same bit in one cycle, the set wins and the bit ends at one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_tx_empty | input | 1 | Event: transmit register emptied |
| ev_tx_underrun | input | 1 | Event: transmit underrun |
| ev_rx_full | input | 1 | Event: receive storage became full |
| ev_rx_overrun | input | 1 | Event: received byte dropped |
| ev_tx_half | input | 1 | Event: transmit FIFO half empty |
| ev_xfer_done | input | 1 | Event: one byte exchange completed |
| lvl_rx_nonempty | input | 1 | Level: receive storage holds data |
| lvl_rx_full | input | 1 | Level: receive storage is full |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that a read and a write never share a cycle. They also assume that `lvl_rx_full` is high only while `lvl_rx_nonempty` is high, and that every event input is a pulse synchronous to `clk`. Both the directed sequences and the random phase respect these limits. The random phase draws at most one of the two strobes per cycle and derives the full level from the non-empty level. It sends writes to all three registers and to an unmapped address, so the toggle, gating and set-wins orderings are all reached.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W = 32;

  // byte offsets on the register port
  localparam int OFF_GIE  = 'h1C;
  localparam int OFF_STAT = 'h20;
  localparam int OFF_EN   = 'h28;

  // status bit positions
  localparam int B_TXE  = 2;
  localparam int B_TXU  = 3;
  localparam int B_RXF  = 4;
  localparam int B_RXO  = 5;
  localparam int B_TXH  = 6;
  localparam int B_RXNE = 8;
  localparam int B_GIE  = 31;

  localparam logic [REG_W-1:0] STAT_MASK =
      (REG_W'(1) << B_TXE) | (REG_W'(1) << B_TXU) | (REG_W'(1) << B_RXF) |
      (REG_W'(1) << B_RXO) | (REG_W'(1) << B_TXH) | (REG_W'(1) << B_RXNE);
  localparam logic [REG_W-1:0] GIE_MASK = REG_W'(1) << B_GIE;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  input  logic             access,
  input  logic [REG_W-1:0] ev_set,
  input  logic [REG_W-1:0] lvl_set,
  output logic [REG_W-1:0] stat_next,
  output logic [REG_W-1:0] stat_q
);
  logic [REG_W-1:0] toggled;

  always_comb begin
    toggled   = stat_q ^ (wr_stat ? wdata : '0);
    stat_next = (toggled | ev_set | (access ? lvl_set : '0)) & STAT_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_next;
  end

  // Without a status write no bit may fall
  assert_no_autoclear_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_level_set_R4: assert property (@(posedge clk) disable iff (rst)
    (access && lvl_set[B_RXNE]) |=> stat_q[B_RXNE]);

  assert_event_set_R2: assert property (@(posedge clk) disable iff (rst)
    ev_set[B_TXU] |=> stat_q[B_TXU]);

  assert_unused_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~STAT_MASK) == '0);
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_gie,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_next,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] gie_next,
  output logic [REG_W-1:0] gie_q
);
  always_comb begin
    en_next  = wr_en  ? (wdata & STAT_MASK) : en_q;
    gie_next = wr_gie ? (wdata & GIE_MASK)  : gie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      gie_q <= '0;
    end else begin
      en_q  <= en_next;
      gie_q <= gie_next;
    end
  end

  assert_gie_only_top_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(gie_q) <= 1 && (gie_q & ~GIE_MASK) == '0);

  assert_en_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] stat_next,
  input  logic [REG_W-1:0] en_next,
  input  logic [REG_W-1:0] gie_next,
  output logic             irq_q
);
  logic pending;

  always_comb pending = gie_next[B_GIE] && (|(stat_next & en_next));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pending;
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ev_tx_empty,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_full,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_half,
  input  logic              ev_xfer_done,
  input  logic              lvl_rx_nonempty,
  input  logic              lvl_rx_full,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFF_GIE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);

  logic             sel_gie, sel_stat, sel_en, access;
  logic [REG_W-1:0] ev_set, lvl_set;
  logic [REG_W-1:0] stat_next, stat_q, en_next, en_q, gie_next, gie_q;
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    sel_gie  = (bus_addr == A_GIE);
    sel_stat = (bus_addr == A_STAT);
    sel_en   = (bus_addr == A_EN);
    access   = bus_rd | bus_wr;

    ev_set = '0;
    ev_set[B_TXE]  = ev_tx_empty | ev_xfer_done;
    ev_set[B_TXU]  = ev_tx_underrun;
    ev_set[B_RXF]  = ev_rx_full;
    ev_set[B_RXO]  = ev_rx_overrun;
    ev_set[B_TXH]  = ev_tx_half;
    ev_set[B_RXNE] = ev_xfer_done;

    lvl_set = '0;
    lvl_set[B_RXNE] = lvl_rx_nonempty;
    lvl_set[B_RXF]  = lvl_rx_full;
  end

  irq_status_reg u_status (
    .clk       (clk),
    .rst       (rst),
    .wr_stat   (bus_wr & sel_stat),
    .wdata     (bus_wdata),
    .access    (access),
    .ev_set    (ev_set),
    .lvl_set   (lvl_set),
    .stat_next (stat_next),
    .stat_q    (stat_q)
  );

  irq_enable_regs u_enable (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr & sel_en),
    .wr_gie   (bus_wr & sel_gie),
    .wdata    (bus_wdata),
    .en_next  (en_next),
    .en_q     (en_q),
    .gie_next (gie_next),
    .gie_q    (gie_q)
  );

  irq_combine u_combine (
    .clk       (clk),
    .rst       (rst),
    .stat_next (stat_next),
    .en_next   (en_next),
    .gie_next  (gie_next),
    .irq_q     (irq)
  );

  always_comb begin
    unique case (1'b1)
      sel_stat: rd_mux = stat_q;
      sel_en:   rd_mux = en_q;
      sel_gie:  rd_mux = gie_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_irq_match_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (gie_q[B_GIE] && (|(stat_q & en_q))));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (!gie_q[B_GIE] && !bus_wr) |=> !irq);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_stat && ev_rx_overrun) |=> stat_q[B_RXO]);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        e_txe = 0, e_txu = 0, e_rxf = 0, e_rxo = 0, e_txh = 0, e_done = 0;
  logic        l_ne = 0, l_full = 0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit started = 0;

  localparam logic [31:0] MASK = 32'h0000_017C;

  always #4 clk = ~clk;

  irq_status_agg u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata),
    .ev_tx_empty(e_txe), .ev_tx_underrun(e_txu), .ev_rx_full(e_rxf),
    .ev_rx_overrun(e_rxo), .ev_tx_half(e_txh), .ev_xfer_done(e_done),
    .lvl_rx_nonempty(l_ne), .lvl_rx_full(l_full), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_stat, m_en, m_gie, m_rdata;
  logic        m_irq;

  always @(posedge clk) begin
    logic [31:0] ev, old;
    if (rst) begin
      m_stat = 0; m_en = 0; m_gie = 0; m_rdata = 0; m_irq = 0;
    end else begin
      if (rd) begin
        case (addr)
          8'h20:   m_rdata = m_stat;
          8'h28:   m_rdata = m_en;
          8'h1C:   m_rdata = m_gie;
          default: m_rdata = 0;
        endcase
      end
      ev = 0;
      if (e_txe || e_done) ev[2] = 1;
      if (e_txu)  ev[3] = 1;
      if (e_rxf)  ev[4] = 1;
      if (e_rxo)  ev[5] = 1;
      if (e_txh)  ev[6] = 1;
      if (e_done) ev[8] = 1;
      if (rd || wr) begin
        if (l_ne)   ev[8] = 1;
        if (l_full) ev[4] = 1;
      end
      old = m_stat;
      if (wr && addr == 8'h20) old = old ^ wdata;
      m_stat = (old | ev) & MASK;
      if (wr && addr == 8'h28) m_en  = wdata & MASK;
      if (wr && addr == 8'h1C) m_gie = wdata & 32'h8000_0000;
      m_irq = m_gie[31] && ((m_stat & m_en) != 0);
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst) begin
      check({31'd0, irq}, {31'd0, m_irq}, "R7 model irq");
      check(rdata, m_rdata, "R8 model rdata");
    end
  end

  task automatic cyc(input logic r, input logic w, input logic [7:0] a, input logic [31:0] d);
    rd = r; wr = w; addr = a; wdata = d;
    @(negedge clk);
    rd = 0; wr = 0;
    e_txe = 0; e_txu = 0; e_rxf = 0; e_rxo = 0; e_txh = 0; e_done = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cyc(1, 0, a, 0);
    check(rdata, exp, tag);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;
    // R1 reset state
    check({31'd0, irq}, 32'd0, "R1 irq");
    check(rdata, 32'd0, "R1 rdata");
    rd_chk(8'h20, 32'h0, "R1 status");
    rd_chk(8'h28, 32'h0, "R1 enable");
    rd_chk(8'h1C, 32'h0, "R1 gie");
    // R2 events
    e_txu = 1; cyc(0, 0, 0, 0);
    rd_chk(8'h20, 32'h008, "R2 underrun");
    e_done = 1; cyc(0, 0, 0, 0);
    rd_chk(8'h20, 32'h10C, "R2 xfer done");
    // R3 toggle
    cyc(0, 1, 8'h20, 32'h008);
    rd_chk(8'h20, 32'h104, "R3 toggle off");
    cyc(0, 1, 8'h20, 32'h020);
    rd_chk(8'h20, 32'h124, "R3 toggle on");
    // R5 unused positions
    cyc(0, 1, 8'h20, 32'hFFFF_FE83);
    rd_chk(8'h20, 32'h124, "R5 unused ignored");
    cyc(0, 1, 8'h20, 32'h124);
    rd_chk(8'h20, 32'h0, "R3 clear all");
    // R4 levels
    l_ne = 1;
    repeat (3) cyc(0, 0, 0, 0);
    rd_chk(8'h20, 32'h0, "R4 no access no set");
    rd_chk(8'h20, 32'h100, "R4 access sets");
    l_ne = 0;
    cyc(0, 0, 0, 0);
    rd_chk(8'h20, 32'h100, "R4 no autoclear");
    l_ne = 1; l_full = 1;
    cyc(0, 1, 8'h40, 32'h0);
    l_ne = 0; l_full = 0;
    rd_chk(8'h20, 32'h110, "R4 full via write");
    cyc(0, 1, 8'h20, 32'h110);
    // R6 enables
    cyc(0, 1, 8'h28, 32'hFFFF_FFFF);
    rd_chk(8'h28, 32'h17C, "R6 enable mask");
    cyc(0, 1, 8'h1C, 32'hFFFF_FFFF);
    rd_chk(8'h1C, 32'h8000_0000, "R6 gie mask");
    check({31'd0, irq}, 32'd0, "R7 idle low");
    // R7 gating
    e_rxo = 1; cyc(0, 0, 0, 0);
    check({31'd0, irq}, 32'd1, "R7 raised");
    cyc(0, 1, 8'h1C, 32'h0);
    check({31'd0, irq}, 32'd0, "R7 gie off");
    cyc(0, 1, 8'h1C, 32'h8000_0000);
    check({31'd0, irq}, 32'd1, "R7 gie on");
    cyc(0, 1, 8'h28, 32'h0);
    check({31'd0, irq}, 32'd0, "R7 enable off");
    // R9 set wins over toggle
    e_rxo = 1; cyc(0, 1, 8'h20, 32'h020);
    rd_chk(8'h20, 32'h020, "R9 set wins");
    // R8 unmapped
    rd_chk(8'h40, 32'h0, "R8 unmapped");
    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [7:0] a;
      k = $urandom_range(0, 3);
      case (k)
        0: a = 8'h1C;
        1: a = 8'h20;
        2: a = 8'h28;
        default: a = 8'h40;
      endcase
      l_ne   = $urandom_range(0, 1);
      l_full = l_ne & ($urandom_range(0, 3) == 0);
      e_txe  = ($urandom_range(0, 7) == 0);
      e_txu  = ($urandom_range(0, 7) == 0);
      e_rxf  = ($urandom_range(0, 7) == 0);
      e_rxo  = ($urandom_range(0, 7) == 0);
      e_txh  = ($urandom_range(0, 7) == 0);
      e_done = ($urandom_range(0, 7) == 0);
      k = $urandom_range(0, 2);
      cyc(k == 1, k == 2, a, $urandom);
    end
    l_ne = 0; l_full = 0;
    cyc(0, 0, 0, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule